// File: doc/BRIEF.md
# Parallel MIDI Host Port

This block sits between an 8-bit microprocessor bus and a synthesizer core. The host selects the block with an active-low chip select, reads with an active-low read strobe, writes with an active-low write strobe, and picks a register with a single address bit. Host writes to the data address pass through a one-entry buffer into the synth core. Host writes to the control address change the operating mode. Host reads return either the receive byte or a status byte. All bus inputs are sampled on a fast system clock through synchronizer flops. Strobe actions take effect on the strobe's rising edge.

The block has two operating modes. After reset it runs in pass-through mode: bytes from the serial MIDI receiver go straight on to the synth core, and the host never sees them. A control command switches the block to raw mode. In raw mode each received serial byte is placed in the receive register and raises the interrupt line, and the synth core sees none of them. Both mode commands queue an acknowledge byte for the host. A data read consumes the pending byte and drops the interrupt.

Top module: `midi_host_port`

## Requirements
- R1: With `addr`=0 a read returns the receive register and a write goes to the synth buffer. With `addr`=1 a read returns the status byte and a write goes to the control decoder.
- R2: `data_oe` is 1 exactly while `cs_n` and `rd_n` are both 0.
- R3: A write takes effect only on the rising edge of `wr_n` while `cs_n` is 0. A write strobe with `cs_n` at 1 changes neither the status nor the synth buffer.
- R4: The rising edge of `rd_n` with `cs_n`=0 and `addr`=0 consumes the pending byte, so status bit 7 returns to 1 and `irq` falls. A status read, or a read with `cs_n` at 1, consumes nothing.
- R5: `irq` equals the pending flag. It rises when the acknowledge byte or a raw-mode serial byte is loaded.
- R6: After `rst_n` and after control byte 0xFF, the block is in pass-through mode. In that mode, a serial byte on `rx_valid`/`rx_byte` appears on `syn_rx_valid`/`syn_rx_byte` in the same cycle and does not touch the receive register.
- R7: Control byte 0xFF selects pass-through mode and control byte 0x3F selects raw mode. Each of the two loads 0xFE into the receive register and sets pending. Any other control byte has no effect.
- R8: In raw mode `syn_rx_valid` stays 0. Each serial byte is loaded into the receive register and sets pending, and a new byte overwrites an unread one.
- R9: A data write fills the one-entry buffer, which shows on `cmd_valid`/`cmd_byte` and holds stable until `cmd_ready`. Status bit 6 is 1 while the buffer is full and 0 while it is empty. A data write into a full buffer is dropped.
- R10: Status bits 5..0 always read as 1.
- R11: Writes with the strobe low for at least 4 clocks and high for at least 4 clocks between them are all accepted. Each takes effect within 3 clocks after the rising edge of `wr_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Host chip select, active low |
| rd_n | input | 1 | Host read strobe, active low |
| wr_n | input | 1 | Host write strobe, active low |
| addr | input | 1 | Register select: 0 data, 1 status/control |
| data_in | input | 8 | Host write data |
| data_out | output | 8 | Host read data |
| data_oe | output | 1 | Bus drive enable for the pad drivers |
| irq | output | 1 | Receive byte pending for the host |
| rx_valid | input | 1 | Serial receiver byte strobe |
| rx_byte | input | 8 | Serial receiver byte |
| syn_rx_valid | output | 1 | Serial byte forwarded to the synth core |
| syn_rx_byte | output | 8 | Forwarded serial byte |
| cmd_valid | output | 1 | Host data byte waiting for the synth core |
| cmd_byte | output | 8 | Host data byte |
| cmd_ready | input | 1 | Synth core accepts the host data byte |

## Verification
The bench targets five corner cases. In the first, the host reads status while a byte is pending; a design that consumed on any read would lose the byte, and the bench sees `irq` drop early. In the second, the host writes while the synth buffer is full; a design that let the write through would replace the unread byte, and the drain would then show the wrong value. In the third, the bench pulses the write strobe with chip select high and sends control bytes other than the two commands; a decoder that was too loose would show a mode change or a spurious acknowledge in the status byte and in the routing. In the fourth, serial bytes arrive around the mode switches; a wrong routing gate would deliver bytes both to the synth and to the host, or to neither. In the fifth, a short strobe checks the latency bound; a design with too many synchronizer stages would miss that deadline.

// File: rtl/mhp_pkg.sv
package mhp_pkg;
   localparam int unsigned BYTE_W = 8;

   function automatic logic [BYTE_W-1:0] status_word(input logic pend, input logic full);
      logic [BYTE_W-1:0] s;
      s = '1;
      s[BYTE_W-1] = ~pend;
      s[BYTE_W-2] = full;
      return s;
   endfunction
endpackage

// File: rtl/mhp_sync.sv
module mhp_sync #(
   parameter int unsigned W = 1,
   parameter int unsigned STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] pipe;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[i] <= RST_VAL;
            else        pipe[i] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[i] <= RST_VAL;
            else        pipe[i] <= pipe[i-1];
         end
      end
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/mhp_rx_reg.sv
module mhp_rx_reg #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_byte,
   input  logic         take,
   output logic         pending,
   output logic [W-1:0] byte_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending <= 1'b0;
         byte_q  <= '0;
      end else if (load) begin
         pending <= 1'b1;
         byte_q  <= load_byte;
      end else if (take) begin
         pending <= 1'b0;
      end
   end
endmodule

// File: rtl/mhp_cmd_slot.sv
module mhp_cmd_slot #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] push_byte,
   output logic         full,
   output logic [W-1:0] out_byte,
   input  logic         out_ready
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full     <= 1'b0;
         out_byte <= '0;
      end else if (!full && push) begin
         full     <= 1'b1;
         out_byte <= push_byte;
      end else if (full && out_ready) begin
         full <= 1'b0;
      end
   end
endmodule

// File: rtl/midi_host_port.sv
module midi_host_port #(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [DATA_W-1:0] CMD_RESET = 8'hFF,
   parameter logic [DATA_W-1:0] CMD_RAW   = 8'h3F,
   parameter logic [DATA_W-1:0] ACK_BYTE  = 8'hFE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic              addr,
   input  logic [DATA_W-1:0] data_in,
   output logic [DATA_W-1:0] data_out,
   output logic              data_oe,
   output logic              irq,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_byte,
   output logic              syn_rx_valid,
   output logic [DATA_W-1:0] syn_rx_byte,
   output logic              cmd_valid,
   output logic [DATA_W-1:0] cmd_byte,
   input  logic              cmd_ready
);
   import mhp_pkg::*;

   localparam int unsigned BUS_W = DATA_W + 4;
   localparam logic [BUS_W-1:0] BUS_IDLE = {3'b111, 1'b0, {DATA_W{1'b0}}};

   if (DATA_W != BYTE_W) begin : g_bad_width
      $error("DATA_W must equal the package byte width");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (CMD_RESET == CMD_RAW) begin : g_bad_cmd
      $error("mode command codes must differ");
   end

   logic [BUS_W-1:0]  bus_s;
   logic              rd_s, wr_s, cs_s, addr_s;
   logic [DATA_W-1:0] data_s;
   logic              rd_prev, wr_prev;
   logic              h_cs_n, h_addr;
   logic [DATA_W-1:0] h_data;
   logic              rd_rise, wr_rise;
   logic              ctl_wr, dat_wr, dat_rd;
   logic              raw_mode;
   logic              ack_load, raw_load, rx_load;
   logic [DATA_W-1:0] rx_load_byte;
   logic              rx_pend;
   logic [DATA_W-1:0] rx_data;
   logic              slot_full;

   mhp_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL(BUS_IDLE)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({rd_n, wr_n, cs_n, addr, data_in}),
      .q     (bus_s)
   );

   assign {rd_s, wr_s, cs_s, addr_s, data_s} = bus_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_prev <= 1'b1;
         wr_prev <= 1'b1;
         h_cs_n  <= 1'b1;
         h_addr  <= 1'b0;
         h_data  <= '0;
      end else begin
         rd_prev <= rd_s;
         wr_prev <= wr_s;
         if (!rd_s || !wr_s) begin
            h_cs_n <= cs_s;
            h_addr <= addr_s;
            h_data <= data_s;
         end
      end
   end

   assign rd_rise = rd_s & ~rd_prev;
   assign wr_rise = wr_s & ~wr_prev;
   assign ctl_wr  = wr_rise & ~h_cs_n &  h_addr;
   assign dat_wr  = wr_rise & ~h_cs_n & ~h_addr;
   assign dat_rd  = rd_rise & ~h_cs_n & ~h_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             raw_mode <= 1'b0;
      else if (ctl_wr && h_data == CMD_RESET) raw_mode <= 1'b0;
      else if (ctl_wr && h_data == CMD_RAW)   raw_mode <= 1'b1;
   end

   assign ack_load     = ctl_wr & ((h_data == CMD_RESET) | (h_data == CMD_RAW));
   assign raw_load     = rx_valid & raw_mode;
   assign rx_load      = ack_load | raw_load;
   assign rx_load_byte = ack_load ? ACK_BYTE : rx_byte;

   mhp_rx_reg #(.W(DATA_W)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (rx_load),
      .load_byte (rx_load_byte),
      .take      (dat_rd),
      .pending   (rx_pend),
      .byte_q    (rx_data)
   );

   mhp_cmd_slot #(.W(DATA_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (dat_wr),
      .push_byte (h_data),
      .full      (slot_full),
      .out_byte  (cmd_byte),
      .out_ready (cmd_ready)
   );

   assign cmd_valid    = slot_full;
   assign irq          = rx_pend;
   assign data_oe      = ~cs_n & ~rd_n;
   assign data_out     = addr ? status_word(rx_pend, slot_full) : rx_data;
   assign syn_rx_valid = rx_valid & ~raw_mode;
   assign syn_rx_byte  = rx_byte;
endmodule

// File: rtl/midi_host_port_chk.sv
module midi_host_port_chk #(
   parameter int unsigned DATA_W = 8,
   parameter logic [DATA_W-1:0] ACK_BYTE = 8'hFE
) (
   input logic              clk,
   input logic              rst_n,
   input logic              irq,
   input logic              raw_mode,
   input logic [DATA_W-1:0] rx_data,
   input logic              rx_load,
   input logic              dat_rd,
   input logic              syn_rx_valid,
   input logic              cmd_valid,
   input logic              cmd_ready,
   input logic [DATA_W-1:0] cmd_byte,
   input logic              data_oe,
   input logic              addr,
   input logic [DATA_W-1:0] data_out
);
   p_raw_no_fwd_r8: assert property (@(posedge clk) disable iff (!rst_n)
      raw_mode |-> !syn_rx_valid);

   p_slot_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_byte)));

   p_raw_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(raw_mode) |-> (irq && rx_data == ACK_BYTE));

   p_irq_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> $past(dat_rd));

   p_irq_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(rx_load));

   p_status_ones_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (data_oe && addr) |-> (data_out[DATA_W-3:0] == '1));
endmodule

bind midi_host_port midi_host_port_chk #(.DATA_W(DATA_W), .ACK_BYTE(ACK_BYTE)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .irq          (irq),
   .raw_mode     (raw_mode),
   .rx_data      (rx_data),
   .rx_load      (rx_load),
   .dat_rd       (dat_rd),
   .syn_rx_valid (syn_rx_valid),
   .cmd_valid    (cmd_valid),
   .cmd_ready    (cmd_ready),
   .cmd_byte     (cmd_byte),
   .data_oe      (data_oe),
   .addr         (addr),
   .data_out     (data_out)
);

// File: tb/midi_host_port_tb_top.sv
`timescale 1ns/1ps
module midi_host_port_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, addr = 1'b0;
   logic [7:0] data_in = '0;
   logic [7:0] data_out;
   logic       data_oe, irq;
   logic       rx_valid = 1'b0;
   logic [7:0] rx_byte = '0;
   logic       syn_rx_valid;
   logic [7:0] syn_rx_byte;
   logic       cmd_valid;
   logic [7:0] cmd_byte;
   logic       cmd_ready = 1'b0;

   int n_tests = 0;
   int n_fail  = 0;

   // reference model state
   logic       m_raw = 1'b0, m_pend = 1'b0, m_full = 1'b0;
   logic [7:0] m_rx = '0, m_slot = '0;

   always #2 clk = ~clk;

   midi_host_port dut_i (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
      .data_in(data_in), .data_out(data_out), .data_oe(data_oe), .irq(irq),
      .rx_valid(rx_valid), .rx_byte(rx_byte), .syn_rx_valid(syn_rx_valid),
      .syn_rx_byte(syn_rx_byte), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
      .cmd_ready(cmd_ready)
   );

   function automatic logic [7:0] exp_status();
      return {~m_pend, m_full, 6'h3F};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic host_write(input logic a, input logic [7:0] d, input logic sel, input int low_len);
      @(negedge clk);
      cs_n = ~sel; addr = a; data_in = d;
      idle(2);
      wr_n = 1'b0;
      idle(low_len);
      wr_n = 1'b1;
      idle(2);
      cs_n = 1'b1;
      idle(4);
      if (sel) begin
         if (a) begin
            if (d == 8'hFF)      begin m_raw = 1'b0; m_pend = 1'b1; m_rx = 8'hFE; end
            else if (d == 8'h3F) begin m_raw = 1'b1; m_pend = 1'b1; m_rx = 8'hFE; end
         end else if (!m_full) begin
            m_full = 1'b1; m_slot = d;
         end
      end
   endtask

   task automatic host_read(input logic a, input logic sel, output logic [7:0] v);
      @(negedge clk);
      cs_n = ~sel; addr = a;
      idle(2);
      rd_n = 1'b0;
      idle(4);
      chk("R2 bus drive during read", data_oe, sel);
      v = data_out;
      rd_n = 1'b1;
      idle(2);
      cs_n = 1'b1;
      idle(4);
      if (sel && !a) m_pend = 1'b0;
   endtask

   task automatic check_status(input string req);
      logic [7:0] v;
      host_read(1'b1, 1'b1, v);
      chk(req, v, exp_status());
      chk("R5 irq follows pending", irq, m_pend);
   endtask

   task automatic check_data(input string req);
      logic [7:0] v;
      logic [7:0] e;
      e = m_rx;
      host_read(1'b0, 1'b1, v);
      chk(req, v, e);
      chk("R4 irq low after data read", irq, 1'b0);
   endtask

   task automatic serial(input logic [7:0] b);
      @(negedge clk);
      rx_valid = 1'b1; rx_byte = b;
      #1;
      if (m_raw) begin
         chk("R8 raw mode no forward", syn_rx_valid, 1'b0);
      end else begin
         chk("R6 pass-through forward", syn_rx_valid, 1'b1);
         chk("R6 pass-through byte", syn_rx_byte, b);
      end
      @(negedge clk);
      rx_valid = 1'b0;
      if (m_raw) begin m_pend = 1'b1; m_rx = b; end
      idle(1);
   endtask

   task automatic drain();
      @(negedge clk);
      chk("R9 buffer valid", cmd_valid, m_full);
      if (m_full) chk("R9 buffer byte", cmd_byte, m_slot);
      cmd_ready = 1'b1;
      @(negedge clk);
      cmd_ready = 1'b0;
      m_full = 1'b0;
      idle(1);
      chk("R9 buffer empty after drain", cmd_valid, 1'b0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog (all) actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : main
      logic [7:0] v;
      void'($urandom(32'h2193_5EED));
      idle(3);
      // reset state
      chk("R2 no drive in reset", data_oe, 1'b0);
      chk("R5 irq low in reset", irq, 1'b0);
      chk("R9 buffer empty in reset", cmd_valid, 1'b0);
      rst_n = 1'b1;
      idle(3);
      check_status("R10 status after reset");

      // R2: chip select low without read does not drive
      @(negedge clk); cs_n = 1'b0; idle(2);
      chk("R2 no drive without read", data_oe, 1'b0);
      cs_n = 1'b1; idle(2);

      // R6: pass-through forwarding, host sees nothing
      serial(8'h90);
      check_status("R6 host untouched in pass-through");

      // R7: other control byte ignored
      host_write(1'b1, 8'h12, 1'b1, 6);
      check_status("R7 unknown control ignored");
      serial(8'h45);

      // R7: raw mode command queues ack
      host_write(1'b1, 8'h3F, 1'b1, 6);
      chk("R5 irq raised by ack", irq, 1'b1);
      check_status("R4 status read does not consume");
      check_data("R7 ack byte after raw command");

      // R8: raw mode delivery and overwrite
      serial(8'h91);
      chk("R5 irq raised by serial byte", irq, 1'b1);
      serial(8'h3C);
      check_data("R8 newest byte overwrites");

      // R4: read with chip select high consumes nothing
      serial(8'h7A);
      host_read(1'b0, 1'b0, v);
      check_status("R4 deselected read consumes nothing");
      check_data("R1 data read returns receive byte");

      // R3: write strobe with chip select high ignored
      host_write(1'b0, 8'h55, 1'b0, 6);
      chk("R3 deselected write ignored", cmd_valid, 1'b0);
      host_write(1'b1, 8'hFF, 1'b0, 6);
      check_status("R3 deselected control ignored");

      // R9: buffer fill, drop when full, drain
      host_write(1'b0, 8'hA1, 1'b1, 6);
      check_status("R9 status shows full");
      host_write(1'b0, 8'hB2, 1'b1, 6);
      drain();
      check_status("R9 status shows empty");

      // R7/R6: reset command back to pass-through
      host_write(1'b1, 8'hFF, 1'b1, 6);
      check_data("R7 ack byte after reset command");
      serial(8'h80);
      check_status("R6 pass-through again");

      // R11: short strobe, effect within 3 clocks
      @(negedge clk);
      cs_n = 1'b0; addr = 1'b0; data_in = 8'hC4;
      idle(4);
      wr_n = 1'b0; idle(4);
      wr_n = 1'b1;
      idle(3);
      chk("R11 write within 3 clocks", cmd_valid, 1'b1);
      chk("R11 write byte", cmd_byte, 8'hC4);
      cs_n = 1'b1;
      m_full = 1'b1; m_slot = 8'hC4;
      idle(4);
      drain();

      // randomized mix
      for (int i = 0; i < 400; i++) begin
         int op;
         op = $urandom_range(0, 7);
         case (op)
            0: serial(8'($urandom));
            1: host_write(1'b0, 8'($urandom), 1'b1, $urandom_range(4, 8));
            2: host_write(1'b1, ($urandom_range(0, 1) != 0) ? 8'h3F : 8'hFF, 1'b1, 5);
            3: host_write(1'b1, 8'($urandom), 1'b1, 5);
            4: check_status("R1 random status read");
            5: check_data("R1 random data read");
            6: drain();
            default: host_write(1'b0, 8'($urandom), 1'b0, 5);
         endcase
      end
      check_status("R10 final status");

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule